// File: doc/BRIEF.md
# Predicated Execution Mask Controller

This block holds the predication state of a SIMD shader core and forms, every cycle, the set of fibers whose results count. It keeps three pieces of state. The first is a base execution mask, which comes from branch handling. The second is a predication mask holding one captured predicate bit per fiber. The third is a two-bit mode that says how the predication mask is applied. The final active mask is the base mask gated by all ones, by the predication mask, or by its complement, depending on the mode.

The decode stage presents one instruction per strobe cycle. Each instruction carries its raw four-bit opcode field, the low bit of the opcode-high field, and a jump-point flag. Three opcode values control predication: enable-on-true, enable-on-false and predication-end. Any instruction with the jump-point flag loads a fresh base mask from the branch unit. The predicate input carries bit p0.x of every fiber, including fibers that are currently inactive. All state changes on the rising clock edge of a strobe cycle. The outputs are driven directly from registers, through the combining logic only.

Top module: `predExecMaskCtl`

## Requirements
- R1: After reset the mode is none (code 2'b00), the predication mask is all zeros, and the base mask is all ones, so every fiber is active.
- R2: The active mask equals the base mask ANDed with a selected mask. In mode none (2'b00) the selected mask is all ones. In mode true (2'b01) it is the predication mask. In mode false (2'b10) it is the inverse of the predication mask. The mode code 2'b11 never appears.
- R3: A strobed enable-on-true instruction (opcode 4'b1101 with the opcode-high low bit 1) loads all fiber predicate bits into the predication mask and sets the mode to true. This includes bits of fibers outside the current active mask.
- R4: A strobed enable-on-false instruction (opcode 4'b1110 with the opcode-high low bit 1) loads all fiber predicate bits into the predication mask and sets the mode to false.
- R5: A strobed predication-end instruction (opcode 4'b1111 with the opcode-high low bit 1) sets the mode to none and leaves the predication mask unchanged.
- R6: A strobed instruction with the jump-point flag set loads the new base mask. Unless the instruction is itself a predication opcode, the mode and the predication mask are kept.
- R7: A predication opcode that also carries the jump-point flag performs both actions in the same edge: the base mask is loaded, and the mask and mode are updated as R3 to R5 specify.
- R8: Opcode values 1101, 1110 and 1111 with the opcode-high low bit 0, and any other opcode value, have no effect on the mode or the predication mask.
- R9: With the strobe low, the base mask, predication mask and mode hold their values whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction strobe for this cycle |
| opCode | input | 4 | Raw opcode field of the instruction |
| opHiLsb | input | 1 | Low bit of the opcode-high field |
| jumpPoint | input | 1 | Jump-point flag: load a new base mask |
| predBits | input | FIBERS | Predicate bit p0.x of every fiber |
| newExecMask | input | FIBERS | Base mask supplied with jump-point instructions |
| activeMask | output | FIBERS | Final per-fiber execution mask |
| predMode | output | 2 | Current mode: 00 none, 01 true, 10 false |
| predMask | output | FIBERS | Stored predication mask |

## Verification
A predication opcode and a jump-point base-mask load can land on the same instruction. Only the predication opcode may then change the mode, while the base mask must still be replaced. The bench issues enable-on-false and predication-end with the jump-point flag set. It judges the outcome by comparing the active mask against the new base mask gated through the newly chosen mode, and by checking that the mode output matches the opcode. It also sends jump-point instructions without a predication opcode and checks that the mode survives them.

// File: rtl/predMaskPkg.sv
package predMaskPkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_TRUE  = 2'b01,
    MODE_FALSE = 2'b10
  } predMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureMask;
    logic loadBase;
  } dpStrobe_t;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_SET_TRUE  = 4'b1101;
  localparam logic [OPC_W-1:0] OPC_SET_FALSE = 4'b1110;
  localparam logic [OPC_W-1:0] OPC_PRED_END  = 4'b1111;

endpackage

// File: rtl/predMaskCtrl.sv
module predMaskCtrl
  import predMaskPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic [OPC_W-1:0]      opCode,
  input  logic                  opHiLsb,
  input  logic                  jumpPoint,
  output dpStrobe_t             dpStrobe,
  output predMode_e             modeQ
);

  logic isSetTrue;
  logic isSetFalse;
  logic isPredEnd;
  predMode_e modeD;

  always_comb begin
    isSetTrue  = instValid && opHiLsb && (opCode == OPC_SET_TRUE);
    isSetFalse = instValid && opHiLsb && (opCode == OPC_SET_FALSE);
    isPredEnd  = instValid && opHiLsb && (opCode == OPC_PRED_END);
  end

  always_comb begin
    modeD = modeQ;
    if (isSetTrue)       modeD = MODE_TRUE;
    else if (isSetFalse) modeD = MODE_FALSE;
    else if (isPredEnd)  modeD = MODE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_NONE;
    else       modeQ <= modeD;
  end

  always_comb begin
    dpStrobe.captureMask = isSetTrue || isSetFalse;
    dpStrobe.loadBase    = instValid && jumpPoint;
  end

endmodule

// File: rtl/predMaskDatapath.sv
module predMaskDatapath
  import predMaskPkg::*;
#(
  parameter int FIBERS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStrobe,
  input  predMode_e         mode,
  input  logic [FIBERS-1:0] predBits,
  input  logic [FIBERS-1:0] newExecMask,
  output logic [FIBERS-1:0] predMaskQ,
  output logic [FIBERS-1:0] activeMask
);

  localparam logic [FIBERS-1:0] ALL_ONES = {FIBERS{1'b1}};

  logic [FIBERS-1:0] baseMaskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predMaskQ <= '0;
      baseMaskQ <= ALL_ONES;
    end else begin
      if (dpStrobe.captureMask) predMaskQ <= predBits;
      if (dpStrobe.loadBase)    baseMaskQ <= newExecMask;
    end
  end

  // Per-fiber gate: pick the predicate term by mode
  for (genvar f = 0; f < FIBERS; f++) begin : g_fiber
    logic gateBit;
    always_comb begin
      unique case (mode)
        MODE_TRUE:  gateBit = predMaskQ[f];
        MODE_FALSE: gateBit = ~predMaskQ[f];
        default:    gateBit = 1'b1;
      endcase
    end
    assign activeMask[f] = baseMaskQ[f] & gateBit;
  end

endmodule

// File: rtl/predExecMaskCtl.sv
module predExecMaskCtl
  import predMaskPkg::*;
#(
  parameter int FIBERS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        opCode,
  input  logic              opHiLsb,
  input  logic              jumpPoint,
  input  logic [FIBERS-1:0] predBits,
  input  logic [FIBERS-1:0] newExecMask,
  output logic [FIBERS-1:0] activeMask,
  output logic [1:0]        predMode,
  output logic [FIBERS-1:0] predMask
);

  dpStrobe_t dpStrobe;
  predMode_e modeQ;

  predMaskCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .opCode    (opCode),
    .opHiLsb   (opHiLsb),
    .jumpPoint (jumpPoint),
    .dpStrobe  (dpStrobe),
    .modeQ     (modeQ)
  );

  predMaskDatapath #(.FIBERS(FIBERS)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .dpStrobe    (dpStrobe),
    .mode        (modeQ),
    .predBits    (predBits),
    .newExecMask (newExecMask),
    .predMaskQ   (predMask),
    .activeMask  (activeMask)
  );

  assign predMode = modeQ;

endmodule

// File: rtl/predExecMaskCtl_chk.sv
module predExecMaskCtl_chk #(
  parameter int FIBERS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [3:0]        opCode,
  input logic              opHiLsb,
  input logic              jumpPoint,
  input logic [FIBERS-1:0] predBits,
  input logic [FIBERS-1:0] activeMask,
  input logic [1:0]        predMode,
  input logic [FIBERS-1:0] predMask
);

  logic predOp;
  assign predOp = opHiLsb && (opCode inside {4'b1101, 4'b1110, 4'b1111});

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    predMode != 2'b11);

  p_true_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (predMode == 2'b01) |-> ((activeMask & ~predMask) == '0));

  p_false_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (predMode == 2'b10) |-> ((activeMask & predMask) == '0));

  p_set_true_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opHiLsb && opCode == 4'b1101)
      |=> (predMode == 2'b01) && (predMask == $past(predBits)));

  p_set_false_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opHiLsb && opCode == 4'b1110)
      |=> (predMode == 2'b10) && (predMask == $past(predBits)));

  p_pred_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opHiLsb && opCode == 4'b1111)
      |=> (predMode == 2'b00) && $stable(predMask));

  p_jp_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && jumpPoint && !predOp) |=> $stable(predMode));

  p_other_op_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !predOp) |=> $stable(predMode) && $stable(predMask));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> $stable(predMode) && $stable(predMask) && $stable(activeMask));

endmodule

bind predExecMaskCtl predExecMaskCtl_chk #(.FIBERS(FIBERS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .opCode     (opCode),
  .opHiLsb    (opHiLsb),
  .jumpPoint  (jumpPoint),
  .predBits   (predBits),
  .activeMask (activeMask),
  .predMode   (predMode),
  .predMask   (predMask)
);

// File: tb/predExecMaskCtl_tb_top.sv
module predExecMaskCtl_tb_top;

  localparam int N = 8;
  localparam int NVEC = 13;

  typedef struct packed {
    logic         valid;
    logic [3:0]   opc;
    logic         hi;
    logic         jp;
    logic [N-1:0] pbits;
    logic [N-1:0] newMask;
    logic [N-1:0] expActive;
    logic [1:0]   expMode;
    logic [N-1:0] expPred;
  } vec_t;

  // Mode codes: 00 none, 01 true, 10 false. Reset base = FF.
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 4'hD, 1'b1, 1'b0, 8'h5A, 8'h00, 8'h5A, 2'b01, 8'h5A}, // R3
    '{1'b1, 4'hE, 1'b1, 1'b0, 8'h0F, 8'h00, 8'hF0, 2'b10, 8'h0F}, // R4
    '{1'b1, 4'h0, 1'b0, 1'b1, 8'hFF, 8'h3C, 8'h30, 2'b10, 8'h0F}, // R6
    '{1'b1, 4'hF, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h3C, 2'b00, 8'h0F}, // R5
    '{1'b1, 4'hD, 1'b1, 1'b0, 8'hC3, 8'h00, 8'h00, 2'b01, 8'hC3}, // R3 inactive fibers
    '{1'b0, 4'hE, 1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 2'b01, 8'hC3}, // R9
    '{1'b1, 4'hD, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 2'b01, 8'hC3}, // R8
    '{1'b1, 4'h0, 1'b0, 1'b1, 8'h00, 8'hF0, 8'hC0, 2'b01, 8'hC3}, // R6
    '{1'b1, 4'hE, 1'b1, 1'b1, 8'h81, 8'hFF, 8'h7E, 2'b10, 8'h81}, // R7
    '{1'b1, 4'hF, 1'b1, 1'b1, 8'h00, 8'h0F, 8'h0F, 2'b00, 8'h81}, // R7
    '{1'b1, 4'hE, 1'b0, 1'b0, 8'h00, 8'h00, 8'h0F, 2'b00, 8'h81}, // R8
    '{1'b1, 4'hD, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 2'b01, 8'h00}, // R3
    '{1'b1, 4'h4, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 2'b01, 8'h00}  // R8
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [3:0] opCode = '0;
  logic opHiLsb = 1'b0;
  logic jumpPoint = 1'b0;
  logic [N-1:0] predBits = '0;
  logic [N-1:0] newExecMask = '0;
  logic [N-1:0] activeMask;
  logic [1:0] predMode;
  logic [N-1:0] predMask;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  predExecMaskCtl #(.FIBERS(N)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opCode(opCode),
    .opHiLsb(opHiLsb), .jumpPoint(jumpPoint), .predBits(predBits),
    .newExecMask(newExecMask), .activeMask(activeMask),
    .predMode(predMode), .predMask(predMask)
  );

  task automatic checkAll(input string tag, input logic [N-1:0] eAct,
                          input logic [1:0] eMode, input logic [N-1:0] ePred);
    nChecks++;
    if (activeMask !== eAct || predMode !== eMode || predMask !== ePred) begin
      nFails++;
      $display("FAIL %s: active=%h mode=%b pred=%h expected active=%h mode=%b pred=%h",
               tag, activeMask, predMode, predMask, eAct, eMode, ePred);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 reset", 8'hFF, 2'b00, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release", 8'hFF, 2'b00, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      instValid   = TBL[i].valid;
      opCode      = TBL[i].opc;
      opHiLsb     = TBL[i].hi;
      jumpPoint   = TBL[i].jp;
      predBits    = TBL[i].pbits;
      newExecMask = TBL[i].newMask;
      @(negedge clk);
      checkAll($sformatf("vector %0d", i), TBL[i].expActive,
               TBL[i].expMode, TBL[i].expPred);
    end

    // R9: several idle cycles with busy inputs
    instValid = 1'b0; opCode = 4'hD; opHiLsb = 1'b1; jumpPoint = 1'b1;
    predBits = 8'hAA; newExecMask = 8'h55;
    repeat (3) @(negedge clk);
    checkAll("R9 idle hold", 8'h00, 2'b01, 8'h00);

    // R2: false mode with full base mask
    instValid = 1'b1; opCode = 4'h0; opHiLsb = 1'b0; jumpPoint = 1'b1;
    newExecMask = 8'hFF;
    @(negedge clk);
    opCode = 4'hE; opHiLsb = 1'b1; jumpPoint = 1'b0; predBits = 8'h96;
    @(negedge clk);
    checkAll("R2 false gate", 8'h69, 2'b10, 8'h96);

    // R1: reset mid-run
    instValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R1 mid-run reset", 8'hFF, 2'b00, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule